// File: doc/BRIEF.md
# Slot-Tagged Data Trace Correlator

The correlator joins the two halves of a data trace. Address-side information is captured early in a processor pipeline and data values are captured later. Both sides carry a small slot tag, and the tag is the only thing that ties a value to its address. For every data value it accepts, the block presents one output beat. The beat holds the address and transfer attributes recorded for that slot, and the data word converted from memory byte order to register byte order.

The address side is a plain sampled bus and cannot be stalled. A slot code of zero means no transfer in that cycle. The all-ones code is kept for the trace unit itself and is never a transfer. Each usable slot keeps the latest address written to it. A slot stays usable after its value has been returned, so a later value on that slot pairs with whatever address was written last. An unaligned access arrives as two address cycles on the same slot. The second cycle inherits the attributes of the first and steps the word address by one 8-byte unit.

The value side and the output form a valid/ready stream. A value is offered whenever `v_slot` holds a usable code, and it is taken in a cycle where `v_ready` is high. While `v_ready` is low the source must hold `v_slot` and `v_word` unchanged. The output beat stays stable until `o_ready` is high. While a value waits, the user must not write a new address to that value's slot. A value whose slot has never been written since reset produces no beat and sets a sticky error.

Top module: `trace_data_correlator`

## Requirements
- R1: A value taken on slot s at a rising edge gives `o_valid`=1 after that edge. The beat carries `o_slot`=s and the word address, lanes, write, non-sequential, last and coprocessor flags stored for s.
- R2: A value pairs with the most recent address on its slot from an earlier cycle. An address written on the same slot in the same cycle as the value takes effect only for later values.
- R3: `o_word` is the input word, first byte-reversed when the stored swizzle flag is 1, then rotated right by 8 times the stored 2-bit rotate count. Example: 0x11223344 with swizzle and rotate 1 gives 0x11443322.
- R4: The address cycle that follows an address with `a_unal`=1 on the same slot is a second half. Its beat has `o_half2`=1 and word address = first-half word address + 1. It takes lanes and last from its own cycle, and rotate, swizzle, write, non-sequential and coprocessor from the first half. Its own `a_waddr`, `a_rot`, `a_swz`, `a_write`, `a_nseq` and `a_unal` are ignored. All other beats have `o_half2`=0.
- R5: For an address cycle with `a_cprt`=1, the stored word address and lanes are zero whatever `a_waddr` and `a_lanes` hold.
- R6: Slot codes 0 and all-ones are not transfers on either side. They store nothing, take no value, produce no beat and do not touch the error flag.
- R7: A taken value on a slot with no address since reset produces no beat and sets `err_orphan`. The flag stays 1 until reset.
- R8: `v_ready` = !`o_valid` | `o_ready`. While `o_valid`=1 and `o_ready`=0, every output field holds its value.
- R9: After reset `o_valid`=0, `err_orphan`=0, `v_ready`=1, and every slot is empty.
- R10: Writing an address to one slot leaves the stored contents of every other slot unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_slot | input | SLOT_W | Address-side slot tag |
| a_waddr | input | WADDR_W | Word address (byte address bits 31:3) |
| a_lanes | input | LANE_W | Byte lane selects |
| a_rot | input | ROT_W | Right-rotate byte count |
| a_swz | input | 1 | Big-endian byte swizzle |
| a_write | input | 1 | Transfer is a write |
| a_nseq | input | 1 | Non-sequential transfer |
| a_last | input | 1 | Last transfer of the instruction |
| a_cprt | input | 1 | Coprocessor register transfer |
| a_unal | input | 1 | First half of an unaligned access |
| v_slot | input | SLOT_W | Value-side slot tag (usable code = valid) |
| v_word | input | DATA_W | Memory-view data word |
| v_ready | output | 1 | Value side may be taken this cycle |
| o_valid | output | 1 | Output beat valid |
| o_ready | input | 1 | Consumer takes the beat |
| o_slot | output | SLOT_W | Slot of the beat |
| o_waddr | output | WADDR_W | Matched word address |
| o_lanes | output | LANE_W | Matched lane selects |
| o_write | output | 1 | Matched write flag |
| o_nseq | output | 1 | Matched non-sequential flag |
| o_last | output | 1 | Matched last flag |
| o_cprt | output | 1 | Matched coprocessor flag |
| o_half2 | output | 1 | Beat is the second half of an unaligned access |
| o_word | output | DATA_W | Register-view data word |
| err_orphan | output | 1 | Sticky: value arrived on an empty slot |

## Verification
The bench builds the block with its defaults: a 2-bit slot tag, which gives two usable slots plus the idle and reserved codes, a 29-bit word address and a 32-bit word. With these values every rotate count and the swizzle can be driven against a known byte pattern. Both reserved codes can be driven on each side, and two live slots make it possible to show that they do not disturb each other. The same-cycle address/value race and the two-cycle unaligned sequence can each be set up on a single slot. The output stall is held for several cycles while a second value waits, so the hold rule and the hand-over when `o_ready` returns can both be observed.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  typedef struct packed {
    logic wr;
    logic nseq;
    logic last;
    logic cprt;
    logic swz;
    logic half2;
  } tdc_flags_t;
endpackage

// File: rtl/tdc_slot_store.sv
module tdc_slot_store
  import tdc_pkg::*;
#(
  parameter int SLOT_W  = 2,
  parameter int WADDR_W = 29,
  parameter int LANE_W  = 8,
  parameter int ROT_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLOT_W-1:0]  wr_slot,
  input  logic [WADDR_W-1:0] wr_waddr,
  input  logic [LANE_W-1:0]  wr_lanes,
  input  logic [ROT_W-1:0]   wr_rot,
  input  logic               wr_write,
  input  logic               wr_nseq,
  input  logic               wr_last,
  input  logic               wr_cprt,
  input  logic               wr_swz,
  input  logic               wr_unal,
  input  logic [SLOT_W-1:0]  rd_slot,
  output logic               rd_hit,
  output logic [WADDR_W-1:0] rd_waddr,
  output logic [LANE_W-1:0]  rd_lanes,
  output logic [ROT_W-1:0]   rd_rot,
  output tdc_flags_t         rd_flags
);
  localparam int NSLOT = 1 << SLOT_W;

  logic               vld_a   [NSLOT];
  logic [WADDR_W-1:0] waddr_a [NSLOT];
  logic [LANE_W-1:0]  lanes_a [NSLOT];
  logic [ROT_W-1:0]   rot_a   [NSLOT];
  tdc_flags_t         flg_a   [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_ent
    if (g == 0 || g == NSLOT - 1) begin : g_none
      // idle and reserved codes own no storage
      assign vld_a[g]   = 1'b0;
      assign waddr_a[g] = '0;
      assign lanes_a[g] = '0;
      assign rot_a[g]   = '0;
      assign flg_a[g]   = '0;
    end else begin : g_live
      logic               vld_q, pend_q;
      logic [WADDR_W-1:0] waddr_q;
      logic [LANE_W-1:0]  lanes_q;
      logic [ROT_W-1:0]   rot_q;
      tdc_flags_t         flg_q;
      logic               sel;
      assign sel = (wr_slot == SLOT_W'(g));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q   <= 1'b0;
          pend_q  <= 1'b0;
          waddr_q <= '0;
          lanes_q <= '0;
          rot_q   <= '0;
          flg_q   <= '0;
        end else if (sel) begin
          vld_q <= 1'b1;
          if (pend_q) begin
            // second half: step address, keep first-half attributes
            pend_q     <= 1'b0;
            waddr_q    <= waddr_q + WADDR_W'(1);
            lanes_q    <= wr_lanes;
            flg_q.last <= wr_last;
            flg_q.half2 <= 1'b1;
          end else begin
            pend_q  <= wr_unal;
            waddr_q <= wr_cprt ? '0 : wr_waddr;
            lanes_q <= wr_cprt ? '0 : wr_lanes;
            rot_q   <= wr_rot;
            flg_q   <= '{wr: wr_write, nseq: wr_nseq, last: wr_last,
                         cprt: wr_cprt, swz: wr_swz, half2: 1'b0};
          end
        end
      end

      assign vld_a[g]   = vld_q;
      assign waddr_a[g] = waddr_q;
      assign lanes_a[g] = lanes_q;
      assign rot_a[g]   = rot_q;
      assign flg_a[g]   = flg_q;
    end
  end

  assign rd_hit   = vld_a[rd_slot];
  assign rd_waddr = waddr_a[rd_slot];
  assign rd_lanes = lanes_a[rd_slot];
  assign rd_rot   = rot_a[rd_slot];
  assign rd_flags = flg_a[rd_slot];
endmodule

// File: rtl/tdc_view_conv.sv
module tdc_view_conv #(
  parameter int DATA_W = 32,
  parameter int ROT_W  = 2
) (
  input  logic [DATA_W-1:0] mem_word,
  input  logic [ROT_W-1:0]  rot,
  input  logic              swz,
  output logic [DATA_W-1:0] reg_word
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0]   swapped;
  logic [DATA_W-1:0]   mixed;
  logic [2*DATA_W-1:0] doubled;

  for (genvar b = 0; b < NB; b++) begin : g_swap
    assign swapped[b*8 +: 8] = mem_word[(NB-1-b)*8 +: 8];
  end

  always_comb begin
    mixed    = swz ? swapped : mem_word;
    doubled  = {mixed, mixed};
    reg_word = DATA_W'(doubled >> {rot, 3'b000});
  end
endmodule

// File: rtl/tdc_out_stage.sv
module tdc_out_stage #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PAY_W-1:0] pay_in,
  input  logic             o_ready,
  output logic             o_valid,
  output logic [PAY_W-1:0] pay_out,
  output logic             take_ok
);
  assign take_ok = !o_valid || o_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      o_valid <= 1'b0;
      pay_out <= '0;
    end else if (load) begin
      o_valid <= 1'b1;
      pay_out <= pay_in;
    end else if (o_ready) begin
      o_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_data_correlator.sv
module trace_data_correlator
  import tdc_pkg::*;
#(
  parameter int SLOT_W  = 2,
  parameter int WADDR_W = 29,
  parameter int LANE_W  = 8,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SLOT_W-1:0]  a_slot,
  input  logic [WADDR_W-1:0] a_waddr,
  input  logic [LANE_W-1:0]  a_lanes,
  input  logic [$clog2(DATA_W/8)-1:0] a_rot,
  input  logic               a_swz,
  input  logic               a_write,
  input  logic               a_nseq,
  input  logic               a_last,
  input  logic               a_cprt,
  input  logic               a_unal,
  input  logic [SLOT_W-1:0]  v_slot,
  input  logic [DATA_W-1:0]  v_word,
  output logic               v_ready,
  output logic               o_valid,
  input  logic               o_ready,
  output logic [SLOT_W-1:0]  o_slot,
  output logic [WADDR_W-1:0] o_waddr,
  output logic [LANE_W-1:0]  o_lanes,
  output logic               o_write,
  output logic               o_nseq,
  output logic               o_last,
  output logic               o_cprt,
  output logic               o_half2,
  output logic [DATA_W-1:0]  o_word,
  output logic               err_orphan
);
  localparam int ROT_W  = $clog2(DATA_W / 8);
  localparam int FLG_W  = $bits(tdc_flags_t);
  localparam int PAY_W  = SLOT_W + WADDR_W + LANE_W + FLG_W + DATA_W;
  localparam logic [SLOT_W-1:0] SLOT_RSV = '1;

  logic               hit;
  logic [WADDR_W-1:0] s_waddr;
  logic [LANE_W-1:0]  s_lanes;
  logic [ROT_W-1:0]   s_rot;
  tdc_flags_t         s_flg, o_flg;
  logic [DATA_W-1:0]  reg_word;
  logic               take, load;
  logic [PAY_W-1:0]   pay_in, pay_out;

  tdc_slot_store #(.SLOT_W(SLOT_W), .WADDR_W(WADDR_W), .LANE_W(LANE_W),
                   .ROT_W(ROT_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_slot(a_slot), .wr_waddr(a_waddr), .wr_lanes(a_lanes), .wr_rot(a_rot),
    .wr_write(a_write), .wr_nseq(a_nseq), .wr_last(a_last), .wr_cprt(a_cprt),
    .wr_swz(a_swz), .wr_unal(a_unal),
    .rd_slot(v_slot), .rd_hit(hit), .rd_waddr(s_waddr), .rd_lanes(s_lanes),
    .rd_rot(s_rot), .rd_flags(s_flg)
  );

  tdc_view_conv #(.DATA_W(DATA_W), .ROT_W(ROT_W)) u_conv (
    .mem_word(v_word), .rot(s_rot), .swz(s_flg.swz), .reg_word(reg_word)
  );

  assign take   = v_ready && (v_slot != '0) && (v_slot != SLOT_RSV);
  assign load   = take && hit;
  assign pay_in = {v_slot, s_waddr, s_lanes, s_flg, reg_word};

  tdc_out_stage #(.PAY_W(PAY_W)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .pay_in(pay_in),
    .o_ready(o_ready), .o_valid(o_valid), .pay_out(pay_out), .take_ok(v_ready)
  );

  assign {o_slot, o_waddr, o_lanes, o_flg, o_word} = pay_out;
  assign o_write = o_flg.wr;
  assign o_nseq  = o_flg.nseq;
  assign o_last  = o_flg.last;
  assign o_cprt  = o_flg.cprt;
  assign o_half2 = o_flg.half2;

  always_ff @(posedge clk) begin
    if (!rst_n)             err_orphan <= 1'b0;
    else if (take && !hit)  err_orphan <= 1'b1;
  end
endmodule

// File: rtl/tdc_checker.sv
module tdc_checker #(
  parameter int SLOT_W  = 2,
  parameter int WADDR_W = 29,
  parameter int DATA_W  = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic [SLOT_W-1:0]  a_slot,
  input logic [SLOT_W-1:0]  v_slot,
  input logic               v_ready,
  input logic               o_valid,
  input logic               o_ready,
  input logic [SLOT_W-1:0]  o_slot,
  input logic [WADDR_W-1:0] o_waddr,
  input logic [DATA_W-1:0]  o_word,
  input logic               err_orphan
);
  localparam int NSLOT = 1 << SLOT_W;
  localparam logic [SLOT_W-1:0] RSV = '1;

  logic [NSLOT-1:0] seen;
  logic             v_live;
  assign v_live = (v_slot != '0) && (v_slot != RSV);

  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (a_slot != '0 && a_slot != RSV) seen[a_slot] <= 1'b1;
  end

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_ready) |=> (o_valid && $stable(o_word) && $stable(o_waddr) && $stable(o_slot)));

  // R8
  ready_rule_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_ready == (!o_valid || o_ready));

  // R7
  orphan_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_ready && v_live && !seen[v_slot]) |=> err_orphan);

  // R7
  orphan_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_orphan |=> err_orphan);

  // R6
  idle_no_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!o_valid && !v_live) |=> !o_valid);

  // R1
  beat_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_valid) |-> ($past(v_ready) && $past(v_slot) == o_slot));
endmodule

bind trace_data_correlator tdc_checker #(
  .SLOT_W(SLOT_W), .WADDR_W(WADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .a_slot(a_slot), .v_slot(v_slot),
  .v_ready(v_ready), .o_valid(o_valid), .o_ready(o_ready), .o_slot(o_slot),
  .o_waddr(o_waddr), .o_word(o_word), .err_orphan(err_orphan)
);

// File: tb/trace_data_correlator_tb.sv
module trace_data_correlator_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  a_slot = '0;
  logic [28:0] a_waddr = '0;
  logic [7:0]  a_lanes = '0;
  logic [1:0]  a_rot = '0;
  logic        a_swz = 0, a_write = 0, a_nseq = 0, a_last = 0, a_cprt = 0, a_unal = 0;
  logic [1:0]  v_slot = '0;
  logic [31:0] v_word = '0;
  logic        v_ready, o_valid;
  logic        o_ready = 1'b1;
  logic [1:0]  o_slot;
  logic [28:0] o_waddr;
  logic [7:0]  o_lanes;
  logic        o_write, o_nseq, o_last, o_cprt, o_half2, err_orphan;
  logic [31:0] o_word;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trace_data_correlator u_dut (
    .clk(clk), .rst_n(rst_n),
    .a_slot(a_slot), .a_waddr(a_waddr), .a_lanes(a_lanes), .a_rot(a_rot),
    .a_swz(a_swz), .a_write(a_write), .a_nseq(a_nseq), .a_last(a_last),
    .a_cprt(a_cprt), .a_unal(a_unal),
    .v_slot(v_slot), .v_word(v_word), .v_ready(v_ready),
    .o_valid(o_valid), .o_ready(o_ready), .o_slot(o_slot), .o_waddr(o_waddr),
    .o_lanes(o_lanes), .o_write(o_write), .o_nseq(o_nseq), .o_last(o_last),
    .o_cprt(o_cprt), .o_half2(o_half2), .o_word(o_word), .err_orphan(err_orphan)
  );

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    a_slot = '0; v_slot = '0; o_ready = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put_addr(input logic [1:0] s, input logic [28:0] wa, input logic [7:0] ln,
                          input logic [1:0] rt, input logic sw, input logic wr,
                          input logic ns, input logic ls, input logic cp, input logic un);
    @(negedge clk);
    a_slot = s; a_waddr = wa; a_lanes = ln; a_rot = rt; a_swz = sw;
    a_write = wr; a_nseq = ns; a_last = ls; a_cprt = cp; a_unal = un;
    @(negedge clk);
    a_slot = '0;
  endtask

  task automatic put_val(input logic [1:0] s, input logic [31:0] w);
    @(negedge clk);
    v_slot = s; v_word = w;
    @(negedge clk);
    v_slot = '0;
  endtask

  task automatic expect_beat(string req, logic [1:0] s, logic [28:0] wa, logic [7:0] ln,
                             logic [5:0] flg, logic [31:0] w);
    check(req, "o_valid", 64'(o_valid), 64'd1);
    check(req, "o_slot", 64'(o_slot), 64'(s));
    check(req, "o_waddr", 64'(o_waddr), 64'(wa));
    check(req, "o_lanes", 64'(o_lanes), 64'(ln));
    check(req, "flags{wr,nseq,last,cprt,half2}",
          64'({o_write, o_nseq, o_last, o_cprt, o_half2}), 64'(flg[5:1]));
    check(req, "o_word", 64'(o_word), 64'(w));
  endtask

  task automatic t_reset();
    do_reset();
    check("R9", "o_valid", 64'(o_valid), 64'd0);
    check("R9", "err_orphan", 64'(err_orphan), 64'd0);
    check("R9", "v_ready", 64'(v_ready), 64'd1);
  endtask

  task automatic t_reserved();
    put_addr(2'b11, 29'h1, 8'hFF, 2'd0, 0, 1, 1, 1, 0, 0);
    put_val(2'b11, 32'hDEADBEEF);
    check("R6", "o_valid after slot 3 value", 64'(o_valid), 64'd0);
    put_val(2'b00, 32'hDEADBEEF);
    check("R6", "o_valid after slot 0 value", 64'(o_valid), 64'd0);
    check("R6", "err_orphan untouched", 64'(err_orphan), 64'd0);
  endtask

  task automatic t_basic();
    put_addr(2'd1, 29'h0123_4567, 8'h0F, 2'd0, 0, 1, 1, 1, 0, 0);
    put_val(2'd1, 32'hCAFEF00D);
    // flg = {wr,nseq,last,cprt,half2,pad}
    expect_beat("R1", 2'd1, 29'h0123_4567, 8'h0F, 6'b111000, 32'hCAFEF00D);
  endtask

  task automatic t_convert();
    put_addr(2'd2, 29'h40, 8'h01, 2'd1, 0, 0, 1, 0, 0, 0);
    put_val(2'd2, 32'h11223344);
    check("R3", "rot1", 64'(o_word), 64'h44112233);
    put_addr(2'd2, 29'h40, 8'h01, 2'd2, 0, 0, 1, 0, 0, 0);
    put_val(2'd2, 32'h11223344);
    check("R3", "rot2", 64'(o_word), 64'h33441122);
    put_addr(2'd2, 29'h40, 8'h01, 2'd0, 1, 0, 1, 0, 0, 0);
    put_val(2'd2, 32'h11223344);
    check("R3", "swz", 64'(o_word), 64'h44332211);
    put_addr(2'd2, 29'h40, 8'h01, 2'd1, 1, 0, 1, 0, 0, 0);
    put_val(2'd2, 32'h11223344);
    check("R3", "swz+rot1", 64'(o_word), 64'h11443322);
  endtask

  task automatic t_recent_and_isolation();
    put_addr(2'd1, 29'h111, 8'h11, 2'd0, 0, 0, 0, 0, 0, 0);
    put_addr(2'd2, 29'h222, 8'h22, 2'd0, 0, 1, 0, 0, 0, 0);
    put_addr(2'd2, 29'h333, 8'h33, 2'd0, 0, 0, 1, 1, 0, 0);
    put_val(2'd2, 32'h0000_0002);
    expect_beat("R2", 2'd2, 29'h333, 8'h33, 6'b011000, 32'h2);
    put_val(2'd1, 32'h0000_0001);
    expect_beat("R10", 2'd1, 29'h111, 8'h11, 6'b000000, 32'h1);
  endtask

  task automatic t_same_cycle();
    put_addr(2'd1, 29'hAAA, 8'hA0, 2'd0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    a_slot = 2'd1; a_waddr = 29'hBBB; a_lanes = 8'hB0; a_rot = 0; a_swz = 0;
    a_write = 1; a_nseq = 0; a_last = 0; a_cprt = 0; a_unal = 0;
    v_slot = 2'd1; v_word = 32'h5;
    @(negedge clk);
    a_slot = '0; v_slot = '0;
    expect_beat("R2", 2'd1, 29'hAAA, 8'hA0, 6'b000000, 32'h5);
    put_val(2'd1, 32'h6);
    expect_beat("R2", 2'd1, 29'hBBB, 8'hB0, 6'b100000, 32'h6);
  endtask

  task automatic t_unaligned();
    put_addr(2'd2, 29'h0100, 8'hF0, 2'd3, 0, 1, 1, 1, 0, 1);
    put_val(2'd2, 32'hA1B2C3D4);
    expect_beat("R4", 2'd2, 29'h0100, 8'hF0, 6'b111000, 32'hB2C3D4A1);
    put_addr(2'd2, 29'h1F1F, 8'h07, 2'd0, 1, 0, 0, 1, 0, 1);
    put_val(2'd2, 32'hA1B2C3D4);
    expect_beat("R4", 2'd2, 29'h0101, 8'h07, 6'b111010, 32'hB2C3D4A1);
    put_addr(2'd2, 29'h0500, 8'h03, 2'd0, 0, 0, 1, 0, 0, 0);
    put_val(2'd2, 32'h77);
    expect_beat("R4", 2'd2, 29'h0500, 8'h03, 6'b010000, 32'h77);
  endtask

  task automatic t_cprt();
    put_addr(2'd1, 29'h1ABCDEF, 8'hFF, 2'd0, 0, 1, 1, 1, 1, 0);
    put_val(2'd1, 32'h12345678);
    expect_beat("R5", 2'd1, 29'h0, 8'h00, 6'b111100, 32'h12345678);
  endtask

  task automatic t_backpressure();
    put_addr(2'd1, 29'h10, 8'h01, 2'd0, 0, 0, 0, 0, 0, 0);
    put_addr(2'd2, 29'h20, 8'h02, 2'd0, 0, 0, 0, 0, 0, 0);
    @(negedge clk);
    o_ready = 1'b0;
    put_val(2'd1, 32'hAAAA0001);
    @(negedge clk);
    v_slot = 2'd2; v_word = 32'hBBBB0002;
    repeat (3) @(negedge clk);
    check("R8", "o_valid held", 64'(o_valid), 64'd1);
    check("R8", "o_word held", 64'(o_word), 64'hAAAA0001);
    check("R8", "o_waddr held", 64'(o_waddr), 64'h10);
    check("R8", "v_ready low", 64'(v_ready), 64'd0);
    o_ready = 1'b1;
    @(negedge clk);
    expect_beat("R8", 2'd2, 29'h20, 8'h02, 6'b000000, 32'hBBBB0002);
    v_slot = '0;
    @(negedge clk);
    check("R8", "drained", 64'(o_valid), 64'd0);
  endtask

  task automatic t_orphan();
    do_reset();
    put_val(2'd2, 32'h99);
    check("R7", "no beat", 64'(o_valid), 64'd0);
    check("R7", "err set", 64'(err_orphan), 64'd1);
    repeat (3) @(negedge clk);
    put_addr(2'd2, 29'h5, 8'h05, 2'd0, 0, 0, 0, 0, 0, 0);
    put_val(2'd2, 32'h9A);
    expect_beat("R7", 2'd2, 29'h5, 8'h05, 6'b000000, 32'h9A);
    check("R7", "err sticky", 64'(err_orphan), 64'd1);
  endtask

  initial begin
    t_reset();
    t_reserved();
    t_basic();
    t_convert();
    t_recent_and_isolation();
    t_same_cycle();
    t_unaligned();
    t_cprt();
    t_backpressure();
    t_orphan();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule